// File: doc/BRIEF.md
# Timer Slave-Mode Counter Controller

This block is a wrap-around up/down counter whose stepping, starting and reloading follow a 4-bit operating-mode field. It serves as the counting core of a general-purpose timer in a system where the counter may be:

- free-running on the local clock;
- driven by two quadrature encoder channels;
- paced, gated, restarted or launched by a trigger signal chosen from a small set of lines.

The two channel inputs and the trigger lines are synchronized before use. A 3-bit select picks the trigger. It is either one of up to four trigger lines, or a pulse that the block produces on every transition of channel 1. The counter runs between zero and a programmable top value. It pulses an update output whenever it wraps and whenever a trigger forces a reload.

A configuration fault can be latched: the level-gated mode combined with the per-transition pulse source. Once latched, it stays set until reset.

Top module: `slv_ctr_top`

## Requirements
- R1: After reset, the counter is 0 and the update pulse, direction output and configuration-error flag are all 0.
- R2: The counter steps once per clock while the enable is 1 in these modes:
  - mode 0000;
  - every reserved mode, 1001 to 1111.

  The direction input picks the direction: 0 counts up and 1 counts down. The direction output shows that input one clock later.
- R3: An up-count from the top value (or above it) goes to 0. A down-count from 0 goes to the top value. Each wrap raises the update output for exactly one clock.
- R4: Mode 0001 steps only on transitions of channel 1, and transitions of channel 2 have no effect.
  - The step is up when the new channel-1 level differs from channel 2, and down otherwise.
  - In all encoder modes the direction output is 1 after a down step and 0 after an up step.
- R5: Mode 0010 steps only on transitions of channel 2, and channel-1 transitions have no effect. The step is up when the new channel-2 level equals channel 1, and down otherwise.
- R6: Mode 0011 applies the channel-1 rule of R4 to channel-1 transitions and the channel-2 rule of R5 to channel-2 transitions. When both channels change in the same sampled cycle, there is no step.
- R7: Mode 0100 steps every clock. A rising trigger edge reloads the counter and raises the update output. The reload value is 0 when the direction input is 0, and the top value when it is 1.
- R8: Mode 0101 steps only while the trigger is high. When the trigger is low, the counter holds its value and is not cleared.
- R9: In mode 0110 the counter is idle until a rising trigger edge. The edge starts it without clearing it. It keeps stepping after the trigger falls, until the enable goes to 0.
- R10: Mode 0111 steps once per rising trigger edge.
- R11: Mode 1000 waits for a rising trigger edge. That edge reloads the counter as in R7, raises the update output, and starts stepping every clock, as in R9.
- R12: The trigger select works as follows:
  - codes 000 to 011 pick trigger line 0 to 3;
  - code 100 picks a one-clock pulse generated on each rising or falling transition of channel 1;
  - codes 101 to 111 give a trigger that stays low.
- R13: The configuration-error flag sets one clock after mode 0101 is selected together with trigger select 100. It stays set until reset.
- R14: While the enable is 0, the counter neither steps nor reloads, and the update output stays 0. The started state of R9 and R11 is cleared, so after the enable returns a new trigger edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Counter enable |
| cnt_dn_i | input | 1 | Direction for non-encoder modes (1 = down) |
| mode_i | input | 4 | Operating mode |
| tsel_i | input | 3 | Trigger source select |
| itr_i | input | N_ITR (4) | Trigger lines |
| ch1_i | input | 1 | Filtered channel 1 |
| ch2_i | input | 1 | Filtered channel 2 |
| arr_i | input | CNT_W (16) | Counter top value |
| cnt_o | output | CNT_W (16) | Counter value |
| dir_o | output | 1 | Current counting direction (1 = down) |
| upd_o | output | 1 | Update pulse on wrap or reload |
| cfg_err_o | output | 1 | Sticky gated/pulse-source misconfiguration flag |

## Verification
Changes on the channels and trigger lines pass through two synchronizer flops and a previous-sample flop. The counter and update output therefore react on the third rising edge after the change. The bench drives on falling edges and samples exactly three falling edges later, so results are checked in the cycle they are due.

A trigger-start needs one extra clock before the first step. This is checked by seeing no step at three and one step at four edges. Enable, direction and mode inputs are not synchronized. Their effect is checked one falling edge later.

Random encoder moves are held for four cycles and compared against a bench quadrature model. A random direction sequence in free-run mode is checked clock by clock against a wrap model.

// File: rtl/slv_pkg.sv
`timescale 1ns/1ps
package slv_pkg;

   typedef enum logic [3:0] {
      SM_OFF    = 4'd0,
      SM_ENC1   = 4'd1,
      SM_ENC2   = 4'd2,
      SM_ENC3   = 4'd3,
      SM_RESET  = 4'd4,
      SM_GATED  = 4'd5,
      SM_TRIG   = 4'd6,
      SM_EXTCLK = 4'd7,
      SM_RSTRIG = 4'd8
   } slv_mode_e;

   localparam logic [2:0] TSEL_CH1_EDGE = 3'd4;

   typedef struct packed {
      logic step;
      logic down;
      logic reload;
      logic set_run;
      logic enc;
   } slv_ctl_t;

endpackage

// File: rtl/slv_sync.sv
`timescale 1ns/1ps
module slv_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] in_i,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] prev_o
);
   logic [STAGES-1:0][W-1:0] stg_q;
   logic [W-1:0]             prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("slv_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q  <= '0;
         prev_q <= '0;
      end else begin
         stg_q  <= {stg_q[STAGES-2:0], in_i};
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign cur_o  = stg_q[STAGES-1];
   assign prev_o = prev_q;
endmodule

// File: rtl/slv_trig_sel.sv
`timescale 1ns/1ps
module slv_trig_sel
   import slv_pkg::*;
#(
   parameter int N_ITR = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       tsel_i,
   input  logic [N_ITR-1:0] itr_cur_i,
   input  logic             ch1_cur_i,
   input  logic             ch1_prev_i,
   output logic             trg_lvl_o,
   output logic             trg_rise_o
);
   logic [3:0] itr_pad;
   logic       trg_prev_q;

   always_comb begin
      itr_pad              = '0;
      itr_pad[N_ITR-1:0]   = itr_cur_i;
      if (tsel_i == TSEL_CH1_EDGE)
         trg_lvl_o = ch1_cur_i ^ ch1_prev_i;
      else if (!tsel_i[2])
         trg_lvl_o = itr_pad[tsel_i[1:0]];
      else
         trg_lvl_o = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trg_prev_q <= 1'b0;
      else        trg_prev_q <= trg_lvl_o;
   end

   assign trg_rise_o = trg_lvl_o & ~trg_prev_q;

   AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      trg_rise_o |=> !trg_rise_o) else $error("rise lasted two cycles"); // R12
endmodule

// File: rtl/slv_mode_dec.sv
`timescale 1ns/1ps
module slv_mode_dec
   import slv_pkg::*;
(
   input  logic       [3:0] mode_i,
   input  logic             cnt_en_i,
   input  logic             cnt_dn_i,
   input  logic       [1:0] ch_cur_i,
   input  logic       [1:0] ch_prev_i,
   input  logic             trg_lvl_i,
   input  logic             trg_rise_i,
   input  logic             run_i,
   output slv_ctl_t         ctl_o
);
   logic e1, e2, up1, up2;

   always_comb begin
      e1  = ch_cur_i[0] ^ ch_prev_i[0];
      e2  = ch_cur_i[1] ^ ch_prev_i[1];
      up1 = ch_cur_i[0] != ch_cur_i[1];
      up2 = ch_cur_i[1] == ch_cur_i[0];

      ctl_o      = '0;
      ctl_o.down = cnt_dn_i;
      ctl_o.enc  = (mode_i == SM_ENC1) || (mode_i == SM_ENC2) || (mode_i == SM_ENC3);

      if (cnt_en_i) begin
         case (slv_mode_e'(mode_i))
            SM_ENC1: begin
               ctl_o.step = e1;
               ctl_o.down = !up1;
            end
            SM_ENC2: begin
               ctl_o.step = e2;
               ctl_o.down = !up2;
            end
            SM_ENC3: begin
               ctl_o.step = e1 ^ e2;
               ctl_o.down = e1 ? !up1 : !up2;
            end
            SM_RESET: begin
               ctl_o.step   = 1'b1;
               ctl_o.reload = trg_rise_i;
            end
            SM_GATED:  ctl_o.step = trg_lvl_i;
            SM_TRIG: begin
               ctl_o.set_run = trg_rise_i;
               ctl_o.step    = run_i;
            end
            SM_EXTCLK: ctl_o.step = trg_rise_i;
            SM_RSTRIG: begin
               ctl_o.reload  = trg_rise_i;
               ctl_o.set_run = trg_rise_i;
               ctl_o.step    = run_i;
            end
            default:   ctl_o.step = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/slv_counter.sv
`timescale 1ns/1ps
module slv_counter
   import slv_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en_i,
   input  slv_ctl_t         ctl_i,
   input  logic [CNT_W-1:0] arr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             dir_o,
   output logic             upd_o,
   output logic             run_o
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             upd_q, upd_d, dir_q, run_q;

   always_comb begin
      cnt_d = cnt_q;
      upd_d = 1'b0;
      if (ctl_i.reload) begin
         cnt_d = ctl_i.down ? arr_i : '0;
         upd_d = 1'b1;
      end else if (ctl_i.step) begin
         if (!ctl_i.down) begin
            if (cnt_q >= arr_i) begin
               cnt_d = '0;
               upd_d = 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end else begin
            if (cnt_q == '0) begin
               cnt_d = arr_i;
               upd_d = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         upd_q <= 1'b0;
         dir_q <= 1'b0;
         run_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         upd_q <= upd_d;
         if (!ctl_i.enc)      dir_q <= ctl_i.down;
         else if (ctl_i.step) dir_q <= ctl_i.down;
         if (!cnt_en_i)          run_q <= 1'b0;
         else if (ctl_i.set_run) run_q <= 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign upd_o = upd_q;
   assign dir_o = dir_q;
   assign run_o = run_q;

   AST_UPD_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> (cnt_q == '0 || cnt_q == $past(arr_i))) else $error("update off boundary"); // R3
   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_q |-> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)
                  || cnt_q == CNT_W'($past(cnt_q) - 1'b1))) else $error("jump without update"); // R2
   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_q) <= $past(arr_i) && $stable(arr_i)) |-> cnt_q <= arr_i) else $error("counter above top"); // R3
endmodule

// File: rtl/slv_ctr_top.sv
`timescale 1ns/1ps
module slv_ctr_top
   import slv_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int N_ITR       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en_i,
   input  logic             cnt_dn_i,
   input  logic [3:0]       mode_i,
   input  logic [2:0]       tsel_i,
   input  logic [N_ITR-1:0] itr_i,
   input  logic             ch1_i,
   input  logic             ch2_i,
   input  logic [CNT_W-1:0] arr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             dir_o,
   output logic             upd_o,
   output logic             cfg_err_o
);
   localparam int SYNC_W = N_ITR + 2;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("CNT_W out of range 2..32");
      end
      if (N_ITR < 1 || N_ITR > 4) begin : g_bad_itr
         $error("N_ITR out of range 1..4");
      end
   endgenerate

   logic [SYNC_W-1:0] s_cur, s_prev;
   logic              trg_lvl, trg_rise, run;
   logic              cfg_err_q;
   slv_ctl_t          ctl;

   slv_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .in_i({itr_i, ch2_i, ch1_i}),
      .cur_o(s_cur), .prev_o(s_prev));

   slv_trig_sel #(.N_ITR(N_ITR)) u_tsel (
      .clk(clk), .rst_n(rst_n), .tsel_i(tsel_i),
      .itr_cur_i(s_cur[SYNC_W-1:2]),
      .ch1_cur_i(s_cur[0]), .ch1_prev_i(s_prev[0]),
      .trg_lvl_o(trg_lvl), .trg_rise_o(trg_rise));

   slv_mode_dec u_dec (
      .mode_i(mode_i), .cnt_en_i(cnt_en_i), .cnt_dn_i(cnt_dn_i),
      .ch_cur_i(s_cur[1:0]), .ch_prev_i(s_prev[1:0]),
      .trg_lvl_i(trg_lvl), .trg_rise_i(trg_rise), .run_i(run), .ctl_o(ctl));

   slv_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en_i), .ctl_i(ctl), .arr_i(arr_i),
      .cnt_o(cnt_o), .dir_o(dir_o), .upd_o(upd_o), .run_o(run));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_err_q <= 1'b0;
      else if (mode_i == SM_GATED && tsel_i == TSEL_CH1_EDGE) cfg_err_q <= 1'b1;
   end
   assign cfg_err_o = cfg_err_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |=> cfg_err_o) else $error("error flag dropped"); // R13
   AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en_i |=> ($stable(cnt_o) && !upd_o)) else $error("moved while disabled"); // R14
   AST_GATED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SM_GATED && !trg_lvl) |=> $stable(cnt_o)) else $error("gated count with trigger low"); // R8
endmodule

// File: tb/sim_slv_ctr_top.sv
`timescale 1ns/1ps
module sim_slv_ctr_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cnt_en, cnt_dn, ch1, ch2;
   logic [3:0]  mode, itr;
   logic [2:0]  tsel;
   logic [15:0] arr, cnt;
   logic        dir, upd, cfg_err;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   slv_ctr_top u0 (
      .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en), .cnt_dn_i(cnt_dn),
      .mode_i(mode), .tsel_i(tsel), .itr_i(itr), .ch1_i(ch1), .ch2_i(ch2),
      .arr_i(arr), .cnt_o(cnt), .dir_o(dir), .upd_o(upd), .cfg_err_o(cfg_err));

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cnt_en = 1'b0; cnt_dn = 1'b0; mode = 4'd0; tsel = 3'd0;
      itr = 4'd0; ch1 = 1'b0; ch2 = 1'b0; arr = 16'd1000;
      wait_n(2);
      rst_n = 1'b1;
      wait_n(1);
   endtask

   function automatic logic [15:0] nxt(input logic [15:0] c, input logic [15:0] a, input bit dn);
      if (!dn) return (c >= a) ? 16'd0 : c + 16'd1;
      return (c == 16'd0) ? a : c - 16'd1;
   endfunction

   function automatic bit wraps(input logic [15:0] c, input logic [15:0] a, input bit dn);
      return dn ? (c == 16'd0) : (c >= a);
   endfunction

   // quadrature model: which 0 = ch1 moved, 1 = ch2 moved, 2 = both
   function automatic int enc_delta(input int which, input bit a, input bit b);
      if (which == 0) return (a != b) ? 1 : -1;
      if (which == 1) return (b == a) ? 1 : -1;
      return 0;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1 got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] exp_c;
      void'($urandom(32'd7));

      // R1 reset state
      do_reset();
      chk("R1 cnt", cnt, 0);
      chk("R1 upd", upd, 0);
      chk("R1 dir", dir, 0);
      chk("R1 cfg_err", cfg_err, 0);

      // R2 + R3 random direction sequence, free-run mode
      do_reset();
      arr = 16'(3 + $urandom % 18);
      exp_c = 16'd0;
      cnt_en = 1'b1;
      for (int i = 0; i < 150; i++) begin
         bit dn;
         bit w;
         dn = 1'($urandom % 2);
         cnt_dn = dn;
         w = wraps(exp_c, arr, dn);
         exp_c = nxt(exp_c, arr, dn);
         wait_n(1);
         chk("R2 random cnt", cnt, exp_c);
         chk("R3 random upd", upd, w);
         chk("R2 dir", dir, dn);
      end

      // R3 directed wrap up
      do_reset();
      arr = 16'd3; cnt_en = 1'b1;
      wait_n(1); chk("R3 step", cnt, 1);
      wait_n(3); chk("R3 wrap cnt", cnt, 0); chk("R3 wrap upd", upd, 1);
      wait_n(1); chk("R3 upd one cycle", upd, 0);

      // R2 reserved code + R14 enable low
      do_reset();
      mode = 4'b1100; cnt_en = 1'b1;
      wait_n(7); chk("R2 reserved counts", cnt, 7);
      cnt_en = 1'b0;
      wait_n(5); chk("R14 hold", cnt, 7);

      // R4 encoder channel 1
      do_reset();
      mode = 4'd1; arr = 16'd100; cnt_en = 1'b1;
      wait_n(4); chk("R4 idle", cnt, 0);
      ch1 = 1'b1; wait_n(3); chk("R4 up latency", cnt, 1); chk("R4 dir up", dir, 0);
      ch2 = 1'b1; wait_n(4); chk("R4 ch2 ignored", cnt, 1);
      ch1 = 1'b0; wait_n(4); chk("R4 up", cnt, 2);
      ch1 = 1'b1; wait_n(4); chk("R4 down", cnt, 1); chk("R4 dir down", dir, 1);

      // R5 encoder channel 2
      do_reset();
      mode = 4'd2; arr = 16'd100; cnt_en = 1'b1;
      wait_n(4);
      ch2 = 1'b1; wait_n(3); chk("R5 down wrap", cnt, 100); chk("R5 wrap upd", upd, 1);
      ch1 = 1'b1; wait_n(4); chk("R5 ch1 ignored", cnt, 100);
      ch2 = 1'b0; wait_n(4); chk("R5 down", cnt, 99);
      ch2 = 1'b1; wait_n(4); chk("R5 up", cnt, 100);

      // R6 both channels: directed then random
      do_reset();
      mode = 4'd3; arr = 16'd100; cnt_en = 1'b1;
      wait_n(4);
      ch1 = 1'b1; wait_n(4);
      ch2 = 1'b1; wait_n(4);
      ch1 = 1'b0; wait_n(4);
      ch2 = 1'b0; wait_n(4); chk("R6 forward cycle", cnt, 4);
      ch2 = 1'b1; wait_n(4); chk("R6 reverse", cnt, 3);
      ch1 = 1'b1; ch2 = 1'b0; wait_n(4); chk("R6 simultaneous", cnt, 3);

      do_reset();
      mode = 4'd3; arr = 16'd12; cnt_en = 1'b1;
      wait_n(4);
      exp_c = 16'd0;
      for (int i = 0; i < 60; i++) begin
         int which;
         int d;
         which = int'($urandom % 3);
         if (which != 1) ch1 = ~ch1;
         if (which != 0) ch2 = ~ch2;
         d = enc_delta(which, ch1, ch2);
         if (d != 0) exp_c = nxt(exp_c, arr, d < 0);
         wait_n(4);
         chk("R6 random cnt", cnt, exp_c);
         if (d != 0) chk("R4 random dir", dir, (d < 0) ? 1 : 0);
      end

      // R7 reset mode, R14 no reload while disabled
      do_reset();
      mode = 4'd4; arr = 16'd50; cnt_en = 1'b1;
      wait_n(10); chk("R7 free count", cnt, 10);
      itr[0] = 1'b1; wait_n(3); chk("R7 reload up", cnt, 0); chk("R7 upd", upd, 1);
      wait_n(1); chk("R7 continues", cnt, 1); chk("R7 upd low", upd, 0);
      itr[0] = 1'b0; wait_n(5); chk("R7 count", cnt, 6);
      cnt_dn = 1'b1; itr[0] = 1'b1; wait_n(3); chk("R7 reload down", cnt, 50);
      wait_n(1); chk("R7 down step", cnt, 49);
      itr[0] = 1'b0; wait_n(4);
      cnt_en = 1'b0; wait_n(1); chk("R14 frozen", cnt, 45);
      itr[0] = 1'b1; wait_n(5); chk("R14 no reload", cnt, 45); chk("R14 no upd", upd, 0);

      // R8 gated
      do_reset();
      mode = 4'd5; tsel = 3'd1; cnt_en = 1'b1;
      wait_n(6); chk("R8 closed", cnt, 0);
      itr[1] = 1'b1; wait_n(3); chk("R8 open", cnt, 1);
      wait_n(4); chk("R8 running", cnt, 5);
      itr[1] = 1'b0; wait_n(10); chk("R8 frozen", cnt, 7);
      wait_n(5); chk("R8 not cleared", cnt, 7);

      // R9 trigger start, R14 run cleared
      do_reset();
      mode = 4'd6; tsel = 3'd2; cnt_en = 1'b1;
      wait_n(5); chk("R9 idle", cnt, 0);
      itr[2] = 1'b1; wait_n(3); chk("R9 not yet", cnt, 0);
      wait_n(1); chk("R9 started", cnt, 1);
      itr[2] = 1'b0; wait_n(5); chk("R9 keeps running", cnt, 6);
      cnt_en = 1'b0; wait_n(3); chk("R14 stop", cnt, 6);
      cnt_en = 1'b1; wait_n(5); chk("R14 needs new trigger", cnt, 6);

      // R10 external clock
      do_reset();
      mode = 4'd7; tsel = 3'd3; cnt_en = 1'b1;
      for (int i = 0; i < 5; i++) begin
         itr[3] = 1'b1; wait_n(4);
         itr[3] = 1'b0; wait_n(4);
      end
      chk("R10 five edges", cnt, 5);

      // R11 combined reset + start
      do_reset();
      mode = 4'd8; arr = 16'd20; cnt_dn = 1'b1; cnt_en = 1'b1;
      wait_n(4); chk("R11 idle", cnt, 0);
      itr[0] = 1'b1; wait_n(3); chk("R11 reload", cnt, 20); chk("R11 upd", upd, 1);
      wait_n(2); chk("R11 running", cnt, 18); chk("R11 upd low", upd, 0);

      // R12 trigger select
      do_reset();
      mode = 4'd7; tsel = 3'd4; cnt_en = 1'b1;
      for (int i = 0; i < 4; i++) begin
         ch1 = ~ch1; wait_n(4);
      end
      chk("R12 ch1 any edge", cnt, 4);
      tsel = 3'd5;
      for (int i = 0; i < 2; i++) begin
         itr = 4'hF; wait_n(4);
         itr = 4'h0; wait_n(4);
      end
      chk("R12 code 5 silent", cnt, 4);
      tsel = 3'd1;
      itr[0] = 1'b1; wait_n(4); itr[0] = 1'b0; wait_n(4);
      chk("R12 other line ignored", cnt, 4);
      itr[1] = 1'b1; wait_n(4); itr[1] = 1'b0; wait_n(4);
      chk("R12 line 1", cnt, 5);

      // R13 configuration error
      do_reset();
      mode = 4'd5; tsel = 3'd3;
      wait_n(2); chk("R13 clear", cfg_err, 0);
      tsel = 3'd4; wait_n(1); chk("R13 set", cfg_err, 1);
      mode = 4'd0; tsel = 3'd0; wait_n(3); chk("R13 sticky", cfg_err, 1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule